// File: doc/BRIEF.md
# Decode Operand Forwarding Selector

This block sits in the decode stage of a five-stage in-order pipeline and picks the two source operand values for the instruction now in decode. Each operand can come from the register file, or it can come from a result that a later instruction has produced but not yet written back. Those results are in the execute, memory or write-back stage. The selection is purely combinational, so the chosen operand is ready within the same cycle in which the decode register IDs and the in-flight results appear.

Five in-flight sources are compared, ordered from youngest producer to oldest:
- the value the ALU is computing right now in execute;
- the data being read from memory;
- the ALU result held in the memory stage;
- the loaded value in write-back;
- the ALU result in write-back.

For call and jump instructions, the first operand carries the incremented PC instead, and no register value is used. For each operand the block also reports a 3-bit code naming the path it took. Stall detection, the register file and the pipeline registers are outside this block. The data flow is a plain combinational datapath, so there is no valid/ready handshake.

Top module: `fwd_operand_select`

## Requirements
- R1: When `dec_icode` equals the call code (default 8) or the jump code (default 7), `opnd_a` equals `dec_pc_next` and `sel_a` is 6. This holds regardless of any register match.
- R2: Otherwise a source ID matches a stage destination ID when the two are equal and not 0xF. The first matching source in the order below is used:
  - execute ALU (`ex_alu`, code 1);
  - memory read data (`mem_rdata`, code 2);
  - memory-stage ALU value (`mem_alu`, code 3);
  - write-back load value (`wb_ldata`, code 4);
  - write-back ALU value (`wb_alu`, code 5).
- R3: When no source matches and R1 does not apply, the operand equals its register-file read port (`rf_a` or `rf_b`) and its select code is 0.
- R4: `opnd_b`/`sel_b` follow the R2/R3 rules keyed on `dec_src_b`. `sel_b` is never 6, even for call and jump codes.
- R5: Register ID 0xF (all ones) means no register. A source of 0xF never matches, and a destination of 0xF is never matched.
- R6: An execute-stage match passes the present value of `ex_alu` to the operand within the same cycle, with no register stage in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_icode | input | 4 | instruction code in decode |
| dec_pc_next | input | 32 | incremented PC of decode instruction |
| dec_src_a | input | 4 | first source register ID |
| dec_src_b | input | 4 | second source register ID |
| ex_dst | input | 4 | execute ALU destination ID |
| ex_alu | input | 32 | ALU result being produced in execute |
| mem_dst_ld | input | 4 | memory-stage load destination ID |
| mem_rdata | input | 32 | data read from memory this cycle |
| mem_dst_alu | input | 4 | memory-stage ALU destination ID |
| mem_alu | input | 32 | ALU value held in memory stage |
| wb_dst_ld | input | 4 | write-back load destination ID |
| wb_ldata | input | 32 | loaded value in write-back |
| wb_dst_alu | input | 4 | write-back ALU destination ID |
| wb_alu | input | 32 | ALU value in write-back |
| rf_a | input | 32 | register-file read port A |
| rf_b | input | 32 | register-file read port B |
| opnd_a | output | 32 | selected first operand |
| opnd_b | output | 32 | selected second operand |
| sel_a | output | 3 | path code for `opnd_a` |
| sel_b | output | 3 | path code for `opnd_b` |

## Verification
The block holds no state, so a defect shows at the ports in the same cycle as the inputs that expose it. A wrong order in the priority chain appears only when two or more stages name the same destination, so every pair of simultaneous matches is driven on each operand and the younger stage must win. A missing no-register guard appears only when IDs equal 0xF. A lost PC override shows only for the two control-transfer codes. These cases are driven deliberately, along with randomized traffic over a small ID set that makes collisions frequent.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int NUM_FWD = 5;
  localparam int SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_RF      = 3'd0,
    SEL_EX_ALU  = 3'd1,
    SEL_MEM_LD  = 3'd2,
    SEL_MEM_ALU = 3'd3,
    SEL_WB_LD   = 3'd4,
    SEL_WB_ALU  = 3'd5,
    SEL_PC      = 3'd6
  } fwd_sel_e;
endpackage

// File: rtl/fwd_hit_vec.sv
// Compares one source ID against every in-flight destination; the
// all-ones ID marks "no register" on either side and never matches.
module fwd_hit_vec #(
  parameter int REG_W = 4,
  parameter int N     = 5
) (
  input  logic [REG_W-1:0]        src,
  input  logic [N-1:0][REG_W-1:0] dst,
  output logic [N-1:0]            hit
);
  localparam logic [REG_W-1:0] NO_REG = '1;

  logic src_real;
  assign src_real = (src != NO_REG);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = src_real && (dst[i] != NO_REG) && (dst[i] == src);
  end
endmodule

// File: rtl/fwd_prio_mux.sv
// Priority select: index 0 is the youngest producer and wins.
// code = 0 means fallback, otherwise index+1.
module fwd_prio_mux #(
  parameter int DATA_W = 32,
  parameter int N      = 5,
  parameter int CODE_W = $clog2(N + 1)
) (
  input  logic [N-1:0]             hit,
  input  logic [N-1:0][DATA_W-1:0] cand,
  input  logic [DATA_W-1:0]        fallback,
  output logic [DATA_W-1:0]        val,
  output logic [CODE_W-1:0]        code
);
  always_comb begin
    val  = fallback;
    code = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        val  = cand[i];
        code = CODE_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/fwd_lane.sv
// One operand path: match, priority pick, optional PC merge.
module fwd_lane
  import fwd_pkg::*;
#(
  parameter int          REG_W     = 4,
  parameter int          DATA_W    = 32,
  parameter int          ICODE_W   = 4,
  parameter bit          WITH_PC   = 1'b0,
  parameter int unsigned CALL_CODE = 8,
  parameter int unsigned JUMP_CODE = 7
) (
  input  logic [ICODE_W-1:0]             icode,
  input  logic [DATA_W-1:0]              pc_next,
  input  logic [REG_W-1:0]               src,
  input  logic [NUM_FWD-1:0][REG_W-1:0]  dst,
  input  logic [NUM_FWD-1:0][DATA_W-1:0] cand,
  input  logic [DATA_W-1:0]              rf,
  output logic [DATA_W-1:0]              val,
  output logic [SEL_W-1:0]               sel
);
  localparam int CODE_W = $clog2(NUM_FWD + 1);

  logic [NUM_FWD-1:0] hit;
  logic [DATA_W-1:0]  fwd_val;
  logic [CODE_W-1:0]  fwd_code;

  fwd_hit_vec #(.REG_W(REG_W), .N(NUM_FWD)) u_hit (
    .src (src),
    .dst (dst),
    .hit (hit)
  );

  fwd_prio_mux #(.DATA_W(DATA_W), .N(NUM_FWD), .CODE_W(CODE_W)) u_pick (
    .hit      (hit),
    .cand     (cand),
    .fallback (rf),
    .val      (fwd_val),
    .code     (fwd_code)
  );

  if (WITH_PC) begin : g_pc
    logic xfer;
    assign xfer = (icode == ICODE_W'(CALL_CODE)) || (icode == ICODE_W'(JUMP_CODE));
    assign val  = xfer ? pc_next : fwd_val;
    assign sel  = xfer ? SEL_PC : SEL_W'(fwd_code);
  end else begin : g_nopc
    logic [ICODE_W-1:0] icode_unused;
    logic [DATA_W-1:0]  pc_unused;
    assign icode_unused = icode;
    assign pc_unused    = pc_next;
    assign val = fwd_val;
    assign sel = SEL_W'(fwd_code);
  end
endmodule

// File: rtl/fwd_operand_select.sv
module fwd_operand_select
  import fwd_pkg::*;
#(
  parameter int          REG_W     = 4,
  parameter int          DATA_W    = 32,
  parameter int          ICODE_W   = 4,
  parameter int unsigned CALL_CODE = 8,
  parameter int unsigned JUMP_CODE = 7
) (
  input  logic [ICODE_W-1:0] dec_icode,
  input  logic [DATA_W-1:0]  dec_pc_next,
  input  logic [REG_W-1:0]   dec_src_a,
  input  logic [REG_W-1:0]   dec_src_b,
  input  logic [REG_W-1:0]   ex_dst,
  input  logic [DATA_W-1:0]  ex_alu,
  input  logic [REG_W-1:0]   mem_dst_ld,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic [REG_W-1:0]   mem_dst_alu,
  input  logic [DATA_W-1:0]  mem_alu,
  input  logic [REG_W-1:0]   wb_dst_ld,
  input  logic [DATA_W-1:0]  wb_ldata,
  input  logic [REG_W-1:0]   wb_dst_alu,
  input  logic [DATA_W-1:0]  wb_alu,
  input  logic [DATA_W-1:0]  rf_a,
  input  logic [DATA_W-1:0]  rf_b,
  output logic [DATA_W-1:0]  opnd_a,
  output logic [DATA_W-1:0]  opnd_b,
  output logic [SEL_W-1:0]   sel_a,
  output logic [SEL_W-1:0]   sel_b
);
  // Youngest producer at index 0.
  logic [NUM_FWD-1:0][REG_W-1:0]  dst_vec;
  logic [NUM_FWD-1:0][DATA_W-1:0] cand_vec;

  assign dst_vec  = {wb_dst_alu, wb_dst_ld, mem_dst_alu, mem_dst_ld, ex_dst};
  assign cand_vec = {wb_alu, wb_ldata, mem_alu, mem_rdata, ex_alu};

  fwd_lane #(
    .REG_W(REG_W), .DATA_W(DATA_W), .ICODE_W(ICODE_W), .WITH_PC(1'b1),
    .CALL_CODE(CALL_CODE), .JUMP_CODE(JUMP_CODE)
  ) u_lane_a (
    .icode   (dec_icode),
    .pc_next (dec_pc_next),
    .src     (dec_src_a),
    .dst     (dst_vec),
    .cand    (cand_vec),
    .rf      (rf_a),
    .val     (opnd_a),
    .sel     (sel_a)
  );

  fwd_lane #(
    .REG_W(REG_W), .DATA_W(DATA_W), .ICODE_W(ICODE_W), .WITH_PC(1'b0),
    .CALL_CODE(CALL_CODE), .JUMP_CODE(JUMP_CODE)
  ) u_lane_b (
    .icode   (dec_icode),
    .pc_next (dec_pc_next),
    .src     (dec_src_b),
    .dst     (dst_vec),
    .cand    (cand_vec),
    .rf      (rf_b),
    .val     (opnd_b),
    .sel     (sel_b)
  );
endmodule

// File: rtl/fwd_operand_select_chk.sv
module fwd_operand_select_chk #(
  parameter int          REG_W     = 4,
  parameter int          DATA_W    = 32,
  parameter int          ICODE_W   = 4,
  parameter int unsigned CALL_CODE = 8,
  parameter int unsigned JUMP_CODE = 7
) (
  input logic [ICODE_W-1:0] dec_icode,
  input logic [DATA_W-1:0]  dec_pc_next,
  input logic [REG_W-1:0]   dec_src_a,
  input logic [REG_W-1:0]   dec_src_b,
  input logic [REG_W-1:0]   ex_dst,
  input logic [DATA_W-1:0]  ex_alu,
  input logic [REG_W-1:0]   mem_dst_ld,
  input logic [DATA_W-1:0]  mem_rdata,
  input logic [REG_W-1:0]   mem_dst_alu,
  input logic [DATA_W-1:0]  mem_alu,
  input logic [REG_W-1:0]   wb_dst_ld,
  input logic [DATA_W-1:0]  wb_ldata,
  input logic [REG_W-1:0]   wb_dst_alu,
  input logic [DATA_W-1:0]  wb_alu,
  input logic [DATA_W-1:0]  rf_a,
  input logic [DATA_W-1:0]  rf_b,
  input logic [DATA_W-1:0]  opnd_a,
  input logic [DATA_W-1:0]  opnd_b,
  input logic [2:0]         sel_a,
  input logic [2:0]         sel_b
);
  localparam logic [REG_W-1:0] NO_REG = '1;

  logic xfer, known;
  assign xfer  = (dec_icode == ICODE_W'(CALL_CODE)) || (dec_icode == ICODE_W'(JUMP_CODE));
  assign known = !$isunknown({dec_icode, dec_src_a, dec_src_b, ex_dst, mem_dst_ld,
                              mem_dst_alu, wb_dst_ld, wb_dst_alu, sel_a, sel_b});

  always_comb begin
    if (known) begin
      a_r1_pc_override: assert (!xfer || (sel_a == 3'd6 && opnd_a == dec_pc_next))
        else $error("R1 PC override violated");
      a_r2_ex_wins_a: assert (xfer || dec_src_a == NO_REG || dec_src_a != ex_dst
                              || (sel_a == 3'd1 && opnd_a == ex_alu))
        else $error("R2 execute priority on A violated");
      a_r2_ex_wins_b: assert (dec_src_b == NO_REG || dec_src_b != ex_dst
                              || (sel_b == 3'd1 && opnd_b == ex_alu))
        else $error("R2 execute priority on B violated");
      a_r3_rf_a: assert (sel_a != 3'd0 || opnd_a == rf_a)
        else $error("R3 register-file path A violated");
      a_r3_rf_b: assert (sel_b != 3'd0 || opnd_b == rf_b)
        else $error("R3 register-file path B violated");
      a_r4_no_pc_b: assert (sel_b <= 3'd5)
        else $error("R4 operand B took PC path");
      a_r5_none_a: assert (dec_src_a != NO_REG || sel_a == 3'd0 || sel_a == 3'd6)
        else $error("R5 no-register source A forwarded");
      a_r5_none_b: assert (dec_src_b != NO_REG || sel_b == 3'd0)
        else $error("R5 no-register source B forwarded");
      a_r2_wb_alu_src: assert (sel_b != 3'd5 || (wb_dst_alu == dec_src_b && opnd_b == wb_alu))
        else $error("R2 write-back ALU path B inconsistent");
      a_r2_mem_ld_src: assert (sel_a != 3'd2 || (mem_dst_ld == dec_src_a && opnd_a == mem_rdata))
        else $error("R2 memory load path A inconsistent");
    end
  end
endmodule

bind fwd_operand_select fwd_operand_select_chk #(
  .REG_W(REG_W), .DATA_W(DATA_W), .ICODE_W(ICODE_W),
  .CALL_CODE(CALL_CODE), .JUMP_CODE(JUMP_CODE)
) u_chk (.*);

// File: tb/tb_fwd_operand_select.sv
module tb_fwd_operand_select;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  logic [3:0]  icode, src_a, src_b;
  logic [31:0] pc_next, rfa, rfb;
  logic [3:0]  dst [5];
  logic [31:0] vals[5];
  logic [31:0] opnd_a, opnd_b;
  logic [2:0]  sel_a, sel_b;

  fwd_operand_select dut (
    .dec_icode(icode), .dec_pc_next(pc_next),
    .dec_src_a(src_a), .dec_src_b(src_b),
    .ex_dst(dst[0]), .ex_alu(vals[0]),
    .mem_dst_ld(dst[1]), .mem_rdata(vals[1]),
    .mem_dst_alu(dst[2]), .mem_alu(vals[2]),
    .wb_dst_ld(dst[3]), .wb_ldata(vals[3]),
    .wb_dst_alu(dst[4]), .wb_alu(vals[4]),
    .rf_a(rfa), .rf_b(rfb),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sel_a(sel_a), .sel_b(sel_b)
  );

  // Behavioural reference: scan stages youngest first.
  task automatic ref_pick(input logic [3:0] src, input bit use_pc, input logic [31:0] rf,
                          output logic [31:0] v, output int s);
    v = rf; s = 0;
    if (use_pc && (icode == 4'd7 || icode == 4'd8)) begin
      v = pc_next; s = 6;
      return;
    end
    if (src == 4'hF) return;
    for (int k = 0; k < 5; k++) begin
      if (dst[k] == src) begin
        v = vals[k]; s = k + 1;
        return;
      end
    end
  endtask

  task automatic compare(input string tag);
    logic [31:0] ea, eb;
    int sa, sb;
    string ta, tb;
    ref_pick(src_a, 1'b1, rfa, ea, sa);
    ref_pick(src_b, 1'b0, rfb, eb, sb);
    ta = (tag != "") ? tag : (sa == 6) ? "R1" : (sa == 0) ? "R3" : "R2";
    tb = (tag != "") ? tag : "R4";
    n_checks++;
    if (opnd_a !== ea || sel_a !== 3'(sa)) begin
      n_fail++;
      $display("FAIL %s operand A: got %h/%0d expected %h/%0d", ta, opnd_a, sel_a, ea, sa);
    end
    n_checks++;
    if (opnd_b !== eb || sel_b !== 3'(sb)) begin
      n_fail++;
      $display("FAIL %s operand B: got %h/%0d expected %h/%0d", tb, opnd_b, sel_b, eb, sb);
    end
  endtask

  task automatic fill_vals();
    for (int k = 0; k < 5; k++) vals[k] = 32'h1000_0000 * (k + 1) + $urandom_range(0, 255);
    rfa = 32'hAAAA_0000 | $urandom_range(0, 255);
    rfb = 32'hBBBB_0000 | $urandom_range(0, 255);
    pc_next = 32'h0000_4000 + $urandom_range(0, 255);
  endtask

  // Drive on falling edge, compare on rising edge.
  task automatic step(input string tag);
    @(posedge clk);
    #1;
    compare(tag);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    icode = 4'd0; src_a = 4'hF; src_b = 4'hF;
    for (int k = 0; k < 5; k++) dst[k] = 4'hF;
    fill_vals();
    @(negedge clk);

    // R3: nothing in flight
    src_a = 4'd2; src_b = 4'd3;
    step("R3");

    // R2 / R4: each pair of simultaneous matches, younger stage wins
    for (int i = 0; i < 5; i++) begin
      for (int j = i + 1; j < 5; j++) begin
        fill_vals();
        for (int k = 0; k < 5; k++) dst[k] = 4'd9;
        dst[i] = 4'd4; dst[j] = 4'd4;
        src_a = 4'd4; src_b = 4'd4; icode = 4'd6;
        step("R2");
        n_checks++;
        if (sel_a !== 3'(i + 1) || sel_b !== 3'(i + 1)) begin
          n_fail++;
          $display("FAIL R2 pair %0d,%0d: got %0d/%0d expected %0d", i, j, sel_a, sel_b, i + 1);
        end
      end
    end

    // R1: call and jump override an execute match; R4: B keeps forwarding
    for (int c = 7; c <= 8; c++) begin
      fill_vals();
      icode = 4'(c);
      dst[0] = 4'd1; src_a = 4'd1; src_b = 4'd1;
      step("");
      n_checks++;
      if (sel_a !== 3'd6 || opnd_a !== pc_next || sel_b !== 3'd1) begin
        n_fail++;
        $display("FAIL R1 code %0d: got %0d/%h sel_b %0d expected 6/%h sel_b 1",
                 c, sel_a, opnd_a, sel_b, pc_next);
      end
    end
    icode = 4'd6;

    // R5: no-register IDs on both sides
    for (int k = 0; k < 5; k++) dst[k] = 4'hF;
    src_a = 4'hF; src_b = 4'hF;
    step("R5");
    src_a = 4'd5; src_b = 4'd5;
    step("R5");
    dst[3] = 4'd5; src_a = 4'hF;
    step("R5");

    // R6: execute value passes through with no clock edge
    fill_vals();
    for (int k = 0; k < 5; k++) dst[k] = 4'd3;
    src_a = 4'd3; src_b = 4'd3;
    #1;
    vals[0] = 32'hDEAD_BEEF;
    #1;
    n_checks++;
    if (opnd_a !== 32'hDEAD_BEEF || opnd_b !== 32'hDEAD_BEEF) begin
      n_fail++;
      $display("FAIL R6: got %h/%h expected deadbeef", opnd_a, opnd_b);
    end
    @(negedge clk);

    // Random traffic over a small ID set, compared every clock
    for (int n = 0; n < 3000; n++) begin
      fill_vals();
      icode = 4'($urandom_range(5, 9));
      for (int k = 0; k < 5; k++) begin
        int r = $urandom_range(0, 3);
        dst[k] = (r == 3) ? 4'hF : 4'(r);
      end
      begin
        int r = $urandom_range(0, 3);
        src_a = (r == 3) ? 4'hF : 4'(r);
        r = $urandom_range(0, 3);
        src_b = (r == 3) ? 4'hF : 4'(r);
      end
      step("");
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule